// File: doc/BRIEF.md
# Polled Byte-Exchange SPI Master

This block is a one-byte-at-a-time SPI master that software drives through four 32-bit registers on a plain memory-mapped bus. One register word holds the chip-select bits and a read-only ready flag. Another holds the clock prescale code, the clock polarity and phase, and a self-clearing receive flush request. Writing the transmit word launches one 8-bit full-duplex exchange, and the byte captured from the slave is read from the receive word. Software controls the chip selects directly. The block never frames them by itself.

Software programs the mode and prescaler, raises one or more selects, writes the transmit byte, polls ready, and reads the captured byte. The bus has no handshake and never stalls. A write completes in the cycle it is presented. Reads are combinational from the address. A write to the transmit word while an exchange is running is dropped, and this is the block's only form of back-pressure. Two configuration bits, fifo-enable and byte-length, are only storage and have no effect.

Top module: `spi_regmaster`

## Requirements
- R1: After reset, the block is in its idle state:
  - every chip-select pin is high;
  - SCLK is low;
  - the control word reads 0x0000_0002;
  - the configuration and receive words read 0.
- R2: The register words are at byte addresses 0x0 (control), 0x4 (configuration), 0x8 (transmit) and 0xC (receive).
  - Configuration bits [4:0] prescale, 5 byte-length, 6 CPHA, 7 CPOL and 17 fifo-enable read back as written.
  - All other configuration bits read 0, except the flush bit.
  - Control bit 1 ignores writes and reads as ready.
  - The transmit word reads 0.
- R3: Writing control bits 16..20 sets chip-select bits 0..4. From the next cycle, pin cs_n[n] is low exactly when bit 16+n is 1.
- R4: A write to the transmit word while ready is 1 starts an exchange of bits [7:0]. Ready reads 0 from the next cycle for exactly 16×D cycles, where D is the divisor of R5.
- R5: The divisor D comes from the prescale code C:
  - if C < 16, D = C;
  - if C ≥ 16, D = 2×(C−16);
  - a result of 0 is taken as 1.
  Each SCLK half-period lasts D clock cycles.
- R6: Bits move MSB first. With CPHA=0, MOSI carries bit 7 before the first SCLK edge, MISO is sampled on odd-numbered (leading) edges, and MOSI changes on even-numbered edges.
- R7: With CPHA=1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R8: Each exchange makes exactly 16 SCLK edges. Whenever no exchange is running, SCLK sits at the configured CPOL level.
- R9: When an exchange ends, the captured byte appears in receive bits [7:0] with bits [31:8] zero. It stays there until the next exchange or a flush.
- R10: Writing configuration bit 9 as 1 makes it read 1 for one cycle. In the next cycle it reads 0 and the receive word reads 0.
- R11: A transmit write while ready is 0 is ignored. The running exchange keeps its byte, its length and its MOSI data.
- R12: Prescale, CPHA and CPOL are captured when an exchange starts. Changing them mid-exchange affects only later exchanges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Qualifies a bus write |
| bus_we | input | 1 | Write enable |
| bus_addr | input | 4 | Byte address, bits [3:2] pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |
| spi_cs_n | output | 5 | Active-low chip selects |

## Verification
The assertions assume that software does not write a flush request in the same cycle in which an exchange finishes, and that bus_addr bits [1:0] are zero. The bench writes flush only while ready reads 1 and uses only word-aligned addresses. The slave model drives MISO only between clock edges, so the sampled bit is always settled. The bench changes CPOL only while the engine is idle. A mid-exchange CPOL change would move the pin level only once the engine is idle again, so it would not disturb the edge count.

// File: rtl/spi_rm_pkg.sv
`timescale 1ns/1ps
package spi_rm_pkg;
  localparam int PRE_W = 5;
  localparam int DIV_W = 5;
  localparam logic [1:0] W_CTRL = 2'd0;
  localparam logic [1:0] W_CFG  = 2'd1;
  localparam logic [1:0] W_TX   = 2'd2;
  localparam logic [1:0] W_RX   = 2'd3;
  localparam int B_READY = 1;
  localparam int B_CS0   = 16;
  localparam int B_LEN   = 5;
  localparam int B_CPHA  = 6;
  localparam int B_CPOL  = 7;
  localparam int B_FLUSH = 9;
  localparam int B_FIFO  = 17;

  typedef struct packed {
    logic             fifo_en;
    logic             flush;
    logic             cpol;
    logic             cpha;
    logic             len_sel;
    logic [PRE_W-1:0] pre;
  } cfg_t;

  // Low codes divide directly, high codes divide in steps of two; zero maps to one.
  function automatic logic [DIV_W-1:0] code_to_div(input logic [PRE_W-1:0] code);
    logic [DIV_W-1:0] d;
    if (code[PRE_W-1]) d = {code[PRE_W-2:0], 1'b0};
    else               d = {1'b0, code[PRE_W-2:0]};
    if (d == '0) d = DIV_W'(1);
    return d;
  endfunction
endpackage

// File: rtl/spi_rm_regs.sv
`timescale 1ns/1ps
module spi_rm_regs
  import spi_rm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ready,
  input  logic [BYTE_W-1:0] rx_byte,
  output cfg_t              cfg,
  output logic [NUM_CS-1:0] cs_bits,
  output logic              start,
  output logic [BYTE_W-1:0] tx_byte
);
  logic [1:0] word;
  logic       wr;
  logic       unused_bits;

  assign word        = bus_addr[3:2];
  assign wr          = bus_sel && bus_we;
  assign start       = wr && (word == W_TX) && ready;
  assign tx_byte     = bus_wdata[BYTE_W-1:0];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_bits <= '0;
      cfg     <= '0;
    end else begin
      if (wr && word == W_CTRL) cs_bits <= bus_wdata[B_CS0 +: NUM_CS];
      if (wr && word == W_CFG) begin
        cfg.pre     <= bus_wdata[PRE_W-1:0];
        cfg.len_sel <= bus_wdata[B_LEN];
        cfg.cpha    <= bus_wdata[B_CPHA];
        cfg.cpol    <= bus_wdata[B_CPOL];
        cfg.fifo_en <= bus_wdata[B_FIFO];
        cfg.flush   <= bus_wdata[B_FLUSH];
      end else if (cfg.flush) begin
        cfg.flush <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (word)
      W_CTRL: begin
        bus_rdata[B_READY]           = ready;
        bus_rdata[B_CS0 +: NUM_CS]   = cs_bits;
      end
      W_CFG: begin
        bus_rdata[PRE_W-1:0] = cfg.pre;
        bus_rdata[B_LEN]     = cfg.len_sel;
        bus_rdata[B_CPHA]    = cfg.cpha;
        bus_rdata[B_CPOL]    = cfg.cpol;
        bus_rdata[B_FLUSH]   = cfg.flush;
        bus_rdata[B_FIFO]    = cfg.fifo_en;
      end
      W_TX: bus_rdata = '0;
      W_RX: bus_rdata[BYTE_W-1:0] = rx_byte;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_rm_clkgen.sv
`timescale 1ns/1ps
module spi_rm_clkgen #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_rm_engine.sv
`timescale 1ns/1ps
module spi_rm_engine #(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  div,
  input  logic              flush,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic [DIV_W-1:0]  div_l,
  output logic              sclk,
  output logic              mosi,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int EDGES  = 2 * BYTE_W;
  localparam int EDGE_W = $clog2(EDGES);

  logic [EDGE_W-1:0] edge_cnt;
  logic [BYTE_W-1:0] tx_sh, rx_sh;
  logic              sclk_r, cpol_l, cpha_l;
  logic              leading, sample, last;

  assign leading = !edge_cnt[0];
  assign sample  = leading ^ cpha_l;
  assign last    = (edge_cnt == EDGE_W'(EDGES - 1));
  assign sclk    = busy ? sclk_r : cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sclk_r   <= 1'b0;
      cpol_l   <= 1'b0;
      cpha_l   <= 1'b0;
      div_l    <= DIV_W'(1);
      edge_cnt <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_byte  <= '0;
      mosi     <= 1'b0;
    end else begin
      if (start && !busy) begin
        busy     <= 1'b1;
        cpol_l   <= cpol;
        cpha_l   <= cpha;
        div_l    <= div;
        sclk_r   <= cpol;
        edge_cnt <= '0;
        rx_sh    <= '0;
        if (!cpha) begin
          mosi  <= tx_byte[BYTE_W-1];
          tx_sh <= {tx_byte[BYTE_W-2:0], 1'b0};
        end else begin
          tx_sh <= tx_byte;
        end
      end else if (busy && tick) begin
        sclk_r   <= ~sclk_r;
        edge_cnt <= edge_cnt + EDGE_W'(1);
        if (sample) rx_sh <= {rx_sh[BYTE_W-2:0], miso};
        if (!sample && !last) begin
          mosi  <= tx_sh[BYTE_W-1];
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
        if (last) begin
          busy    <= 1'b0;
          rx_byte <= sample ? {rx_sh[BYTE_W-2:0], miso} : rx_sh;
        end
      end
      if (flush) rx_byte <= '0;
    end
  end
endmodule

// File: rtl/spi_regmaster.sv
`timescale 1ns/1ps
module spi_regmaster
  import spi_rm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  cfg_t              cfg;
  logic [NUM_CS-1:0] cs_bits;
  logic              start, busy, ready, tick;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic [DIV_W-1:0]  div_req, div_l;
  logic              unused_cfg;

  assign ready      = !busy;
  assign div_req    = code_to_div(cfg.pre);
  assign unused_cfg = ^{cfg.fifo_en, cfg.len_sel};

  spi_rm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ready(ready), .rx_byte(rx_byte),
    .cfg(cfg), .cs_bits(cs_bits), .start(start), .tx_byte(tx_byte)
  );

  spi_rm_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_l), .tick(tick)
  );

  spi_rm_engine #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte), .cpol(cfg.cpol),
    .cpha(cfg.cpha), .div(div_req), .flush(cfg.flush), .tick(tick), .miso(spi_miso),
    .busy(busy), .div_l(div_l), .sclk(spi_sclk), .mosi(spi_mosi), .rx_byte(rx_byte)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs_n[i] = ~cs_bits[i];
  end
endmodule

// File: rtl/spi_rm_checker.sv
`timescale 1ns/1ps
module spi_rm_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 5,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              ready,
  input logic              cfg_flush,
  input logic              cfg_cpol,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              spi_sclk,
  input logic [NUM_CS-1:0] spi_cs_n
);
  logic wr_ctrl, wr_cfg, wr_tx;
  assign wr_ctrl = bus_sel && bus_we && bus_addr[3:2] == 2'd0;
  assign wr_cfg  = bus_sel && bus_we && bus_addr[3:2] == 2'd1;
  assign wr_tx   = bus_sel && bus_we && bus_addr[3:2] == 2'd2;

  AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && ready) |=> !ready); // R4
  AST_CS_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (spi_cs_n == ~$past(bus_wdata[16 +: NUM_CS]))); // R3
  AST_FLUSH_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flush && !(wr_cfg && bus_wdata[9])) |=> !cfg_flush); // R10
  AST_FLUSH_EMPTIES_RX: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_flush |=> (rx_byte == '0)); // R10
  AST_SCLK_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready) && $stable(cfg_cpol)) |-> $stable(spi_sclk)); // R8
  AST_RX_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready) && !$past(cfg_flush)) |-> $stable(rx_byte)); // R9
endmodule

bind spi_regmaster spi_rm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ready(ready), .cfg_flush(cfg.flush), .cfg_cpol(cfg.cpol),
  .rx_byte(rx_byte), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n)
);

// File: tb/tb_spi_regmaster.sv
`timescale 1ns/1ps
module tb_spi_regmaster;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso = 0;
  logic [4:0]  spi_cs_n;

  spi_regmaster dut (.*);

  always #2 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  // reference model state
  int rem = 0;
  logic m_cpol = 0, m_cpha = 0;
  logic [4:0] m_pre = 0, m_cs = 0;
  bit new_xfer = 0;
  // slave model state
  int e = 0;
  logic s_cpha = 0, s_prev = 0;
  logic [7:0] resp = 0, got = 0;

  function automatic int div_for(input logic [4:0] c);
    int d;
    d = (c < 16) ? int'(c) : 2 * (int'(c) - 16);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      if (rem > 0) rem--;
      else if (bus_sel && bus_we && bus_addr[3:2] == 2) begin
        rem = 16 * div_for(m_pre);
        s_cpha = m_cpha;
        new_xfer = 1;
      end
      if (bus_sel && bus_we && bus_addr[3:2] == 0) m_cs = bus_wdata[20:16];
      if (bus_sel && bus_we && bus_addr[3:2] == 1) begin
        m_pre = bus_wdata[4:0]; m_cpha = bus_wdata[6]; m_cpol = bus_wdata[7];
      end
    end
  end

  always @(negedge clk) begin
    #0.5;
    if (rst_n) begin
      if (!bus_sel && bus_addr == 0)
        chk(bus_rdata[1] == (rem == 0), "R4 ready", {31'b0, bus_rdata[1]}, {31'b0, rem == 0});
      chk(spi_cs_n == ~m_cs, "R3 cs pins", {27'b0, spi_cs_n}, {27'b0, ~m_cs});
      if (rem == 0) chk(spi_sclk == m_cpol, "R8 idle sclk", {31'b0, spi_sclk}, {31'b0, m_cpol});
      if (new_xfer) begin
        new_xfer = 0; e = 0; got = 0; s_prev = spi_sclk; spi_miso = resp[7];
      end else if (spi_sclk !== s_prev) begin
        int idx;
        s_prev = spi_sclk;
        e++;
        if (s_cpha ? (e % 2 == 0) : (e % 2 == 1)) got = {got[6:0], spi_mosi};
        idx = s_cpha ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
        if (idx < 8) spi_miso = resp[7 - idx];
      end
    end
  end

  always @(posedge clk) if (cycles > 100000) begin
    fails++;
    $display("FAIL watchdog actual=%0d expected<100000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #0.2; d = bus_rdata; bus_addr = 0; #0.1;
  endtask

  task automatic wait_ready(output int n);
    logic [31:0] d;
    n = 0;
    forever begin
      bus_read(0, d);
      if (d[1]) break;
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic xfer(input logic cpol, input logic cpha, input logic [4:0] code,
                      input logic [7:0] tx, input logic [7:0] rs, input string req);
    int n;
    logic [31:0] d;
    bus_write(4, {24'b0, cpol, cpha, 1'b0, code});
    resp = rs;
    bus_write(8, {24'b0, tx});
    wait_ready(n);
    chk(n == 16 * div_for(code), "R4/R5 busy length", n, 16 * div_for(code));
    chk(got == tx, {req, " mosi bits"}, {24'b0, got}, {24'b0, tx});
    chk(e == 16, "R8 edge count", e, 16);
    bus_read(12, d);
    chk(d == {24'b0, rs}, "R9 rx word", d, {24'b0, rs});
  endtask

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    bus_read(0, d);  chk(d == 32'h2, "R1 ctrl", d, 32'h2);
    bus_read(4, d);  chk(d == 0, "R1 cfg", d, 0);
    bus_read(12, d); chk(d == 0, "R1 rx", d, 0);
    chk(spi_cs_n == 5'h1F, "R1 cs", {27'b0, spi_cs_n}, 32'h1F);
    chk(spi_sclk == 0, "R1 sclk", {31'b0, spi_sclk}, 0);
    // R2 readback
    bus_write(4, 32'hFFFF_FFFF);
    bus_read(4, d);  chk(d == 32'h0002_02FF, "R2 cfg with flush", d, 32'h0002_02FF);
    @(negedge clk); #1;
    bus_read(4, d);  chk(d == 32'h0002_00FF, "R2 cfg stored", d, 32'h0002_00FF);
    bus_read(8, d);  chk(d == 0, "R2 tx reads zero", d, 0);
    bus_write(4, 0);
    // R3 chip selects
    bus_write(0, 32'h0015_0000);
    chk(spi_cs_n == 5'b01010, "R3 cs pattern", {27'b0, spi_cs_n}, 32'h0A);
    bus_read(0, d);  chk(d == 32'h0015_0002, "R2 ctrl readback", d, 32'h0015_0002);
    bus_write(0, 32'hFFFF_FFFD);
    bus_read(0, d);  chk(d == 32'h001F_0002, "R2 ready read-only", d, 32'h001F_0002);
    bus_write(0, 32'h0001_0000);
    // R5, R6, R7 modes and divisors
    xfer(0, 0, 5'h02, 8'hA5, 8'h3C, "R6 mode0");
    xfer(0, 1, 5'h01, 8'h81, 8'h7E, "R7 mode1");
    xfer(1, 0, 5'h11, 8'h5A, 8'hC3, "R6 mode2");
    xfer(1, 1, 5'h03, 8'hF0, 8'h0F, "R7 mode3");
    xfer(0, 0, 5'h00, 8'h01, 8'h80, "R5 code0");
    xfer(0, 1, 5'h10, 8'h80, 8'h01, "R5 code16");
    xfer(1, 0, 5'h0F, 8'h69, 8'h96, "R5 code15");
    xfer(0, 1, 5'h1F, 8'h96, 8'h69, "R5 code31");
    // R11 ignored write while busy
    bus_write(4, 32'h0000_0002);
    resp = 8'h55;
    bus_write(8, 32'h0000_00C3);
    repeat (5) @(negedge clk); #1;
    bus_write(8, 32'h0000_0011);
    wait_ready(n);
    chk(n == 32 - 6, "R11 busy length", n, 26);
    chk(got == 8'hC3, "R11 mosi kept", {24'b0, got}, 32'hC3);
    bus_read(12, d); chk(d == 32'h55, "R11 rx", d, 32'h55);
    // R12 mid-exchange config change
    resp = 8'hE7;
    bus_write(8, 32'h0000_0024);
    repeat (3) @(negedge clk); #1;
    bus_write(4, 32'h0000_0045);
    wait_ready(n);
    chk(n == 32 - 4, "R12 old divisor kept", n, 28);
    chk(got == 8'h24, "R12 old phase kept", {24'b0, got}, 32'h24);
    bus_read(12, d); chk(d == 32'hE7, "R12 rx", d, 32'hE7);
    xfer(0, 1, 5'h05, 8'h3A, 8'hA3, "R12 new settings");
    // R10 flush
    bus_write(4, 32'h0000_0245);
    bus_read(4, d);  chk(d[9] == 1, "R10 flush set", d, 32'h245);
    @(negedge clk); #1;
    bus_read(4, d);  chk(d == 32'h45, "R10 flush cleared", d, 32'h45);
    bus_read(12, d); chk(d == 0, "R10 rx emptied", d, 0);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule